// File: doc/BRIEF.md
# Annul-aware extended I/O decoder

This block decodes processor bus transfers aimed at memory regions that have no dedicated chip select. On the clock where the processor marks the start of a transfer, it matches the address against a set of programmable windows and samples the cancel (annul) indication. That clock alone decides whether the transfer runs. An accepted transfer drives the window's chip select and a read or write enable. It then counts the window's wait states and ends with a one-cycle ready pulse. A cancelled transfer leaves every output low.

The annul level is meaningless outside the first clock of a transfer, so it is ignored everywhere else. The processor raises it in the second data cycle of every store, and it can also raise it early, while a wait-stated access is still running. Neither case may abort a transfer already in progress. Writes are always gated by annul, because a cancelled write could store a floating data bus. Each window has a read-skip input that lets reads proceed even when annulled, for peripherals that tolerate spurious reads. An address that matches no window raises a one-cycle error pulse, but only when the transfer was not annulled.

Top module: `annul_xio_decoder`

## Requirements
- R1: While rst_ni is low, cs_o, we_o, re_o, rdy_o and err_o are all 0.
- R2: A read (write_i=0) whose first cycle has annul_i=0 and whose address hits window i sets cs_o[i] and re_o from the clock after start_i until the ready cycle, with we_o kept low.
- R3: A write (write_i=1) that hits window i with annul_i=0 in its first cycle sets cs_o[i] and we_o, never re_o. we_o and re_o are never high together.
- R4: A write whose first cycle has annul_i=1 produces no chip select, no write enable, no ready pulse and no error, whatever the read-skip setting.
- R5: A read whose first cycle has annul_i=1 is cancelled in the same way when the read-skip bit of the hit window is 0.
- R6: When the read-skip bit of the hit window is 1, an annulled read runs exactly like a normal read.
- R7: annul_i is ignored in every cycle except the start cycle of an accepted start. This covers a store's second data cycle and an early assertion during a preceding wait-stated access.
- R8: A start whose address matches no window drives no chip select. It pulses err_o for one cycle, sampled one clock after start, when annul_i=0, and leaves err_o low when annul_i=1.
- R9: When several windows match, the lowest-numbered window wins, and cs_o is always one-hot or zero.
- R10: With a wait count w (0 to 7), rdy_o is high for exactly one cycle, w+2 clock edges after the start edge.
- R11: A start_i arriving while a transfer is in its active or wait phase is ignored, and cs_o holds its value. A start in the ready cycle is accepted, so transfers can follow back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | First cycle of a bus transfer |
| write_i | input | 1 | Direction: 1 write, 0 read |
| addr_i | input | AW | Transfer address |
| annul_i | input | 1 | Cancel indication, meaningful only with start_i |
| win_base_i | input | NWIN x AW | Per-window base address |
| win_mask_i | input | NWIN x AW | Per-window compare mask (1 = bit compared) |
| win_wait_i | input | NWIN x WAIT_W | Per-window wait-state count |
| win_rd_skip_i | input | NWIN | Per-window: reads bypass the annul check |
| cs_o | output | NWIN | One-hot chip select |
| we_o | output | 1 | Write enable |
| re_o | output | 1 | Read enable |
| rdy_o | output | 1 | One-cycle ready/data strobe |
| err_o | output | 1 | Unmapped-address error pulse |

## Verification
The hardest situation to reach is one where annul is high across the boundary between two transfers. It must be held through the wait phase of an accepted access, then dropped exactly at the next start so that transfer proceeds, then kept high into a store's second cycle. After that it must be high at the start after next so that transfer is cancelled. The bench reaches this by chaining three transfers cycle by cycle and issuing each new start in the ready cycle of the one before. It checks that the first two complete with their ready pulses in place and that the third leaves every strobe low.

// File: rtl/xio_pkg.sv
package xio_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_WAIT   = 2'd2,
    ST_DONE   = 2'd3
  } xio_state_e;
endpackage

// File: rtl/xio_window_match.sv
module xio_window_match #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] mask_i,
  output logic          hit_o
);
  assign hit_o = ((addr_i ^ base_i) & mask_i) == '0;
endmodule

// File: rtl/xio_gate.sv
module xio_gate #(
  parameter int NWIN = 2
) (
  input  logic            start_i,
  input  logic            accepting_i,
  input  logic            write_i,
  input  logic            annul_i,
  input  logic [NWIN-1:0] hit_i,
  input  logic [NWIN-1:0] rd_skip_i,
  output logic [NWIN-1:0] sel_o,
  output logic            go_o,
  output logic            err_set_o
);
  logic take, cancel;

  // lowest index wins
  always_comb begin
    sel_o = '0;
    for (int i = NWIN-1; i >= 0; i--) begin
      if (hit_i[i]) begin
        sel_o    = '0;
        sel_o[i] = 1'b1;
      end
    end
  end

  assign take      = start_i && accepting_i;
  assign cancel    = annul_i && (write_i || !(|(sel_o & rd_skip_i)));
  assign go_o      = take && (|sel_o) && !cancel;
  assign err_set_o = take && !(|hit_i) && !annul_i;
endmodule

// File: rtl/xio_seq.sv
module xio_seq
  import xio_pkg::*;
#(
  parameter int NWIN   = 2,
  parameter int WAIT_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic              write_i,
  input  logic [NWIN-1:0]   sel_i,
  input  logic [WAIT_W-1:0] wait_i,
  output logic              accepting_o,
  output logic [NWIN-1:0]   cs_o,
  output logic              we_o,
  output logic              re_o,
  output logic              rdy_o
);
  xio_state_e        state_q, state_d;
  logic [NWIN-1:0]   sel_q;
  logic              wr_q;
  logic [WAIT_W-1:0] cnt_q;
  logic              strobe;

  assign accepting_o = (state_q == ST_IDLE) || (state_q == ST_DONE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_DONE: state_d = go_i ? ST_ACTIVE : ST_IDLE;
      ST_ACTIVE:        state_d = (cnt_q == '0) ? ST_DONE : ST_WAIT;
      ST_WAIT:          state_d = (cnt_q == WAIT_W'(1)) ? ST_DONE : ST_WAIT;
      default:          state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sel_q   <= '0;
      wr_q    <= 1'b0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (accepting_o && go_i) begin
        sel_q <= sel_i;
        wr_q  <= write_i;
        cnt_q <= wait_i;
      end else if (state_q == ST_WAIT) begin
        cnt_q <= cnt_q - WAIT_W'(1);
      end
    end
  end

  assign strobe = (state_q == ST_ACTIVE) || (state_q == ST_WAIT);
  assign cs_o   = (state_q != ST_IDLE) ? sel_q : '0;
  assign we_o   = strobe && wr_q;
  assign re_o   = strobe && !wr_q;
  assign rdy_o  = (state_q == ST_DONE);

  assert_we_re_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_o && re_o));
  assert_cs_onehot_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cs_o));
  assert_busy_cs_stable_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accepting_o |=> $stable(cs_o));
  assert_rdy_after_strobe_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdy_o && !$past(rdy_o)) |-> $past(we_o || re_o));
endmodule

// File: rtl/annul_xio_decoder.sv
module annul_xio_decoder #(
  parameter int NWIN   = 2,
  parameter int AW     = 16,
  parameter int WAIT_W = 3
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         start_i,
  input  logic                         write_i,
  input  logic [AW-1:0]                addr_i,
  input  logic                         annul_i,
  input  logic [NWIN-1:0][AW-1:0]      win_base_i,
  input  logic [NWIN-1:0][AW-1:0]      win_mask_i,
  input  logic [NWIN-1:0][WAIT_W-1:0]  win_wait_i,
  input  logic [NWIN-1:0]              win_rd_skip_i,
  output logic [NWIN-1:0]              cs_o,
  output logic                         we_o,
  output logic                         re_o,
  output logic                         rdy_o,
  output logic                         err_o
);
  logic [NWIN-1:0]   hit, sel;
  logic [WAIT_W-1:0] wait_sel;
  logic              go, err_set, accepting, err_q;

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    xio_window_match #(.AW(AW)) i_match (
      .addr_i (addr_i),
      .base_i (win_base_i[g]),
      .mask_i (win_mask_i[g]),
      .hit_o  (hit[g])
    );
  end

  xio_gate #(.NWIN(NWIN)) i_gate (
    .start_i     (start_i),
    .accepting_i (accepting),
    .write_i     (write_i),
    .annul_i     (annul_i),
    .hit_i       (hit),
    .rd_skip_i   (win_rd_skip_i),
    .sel_o       (sel),
    .go_o        (go),
    .err_set_o   (err_set)
  );

  always_comb begin
    wait_sel = '0;
    for (int i = 0; i < NWIN; i++)
      if (sel[i]) wait_sel |= win_wait_i[i];
  end

  xio_seq #(.NWIN(NWIN), .WAIT_W(WAIT_W)) i_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .go_i        (go),
    .write_i     (write_i),
    .sel_i       (sel),
    .wait_i      (wait_sel),
    .accepting_o (accepting),
    .cs_o        (cs_o),
    .we_o        (we_o),
    .re_o        (re_o),
    .rdy_o       (rdy_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= err_set;
  end
  assign err_o = err_q;

  assert_annul_wr_blocked_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accepting && start_i && write_i && annul_i) |=> (cs_o == '0 && !we_o && !err_o && !rdy_o));
  assert_annul_rd_blocked_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accepting && start_i && !write_i && annul_i && (win_rd_skip_i == '0)) |=> (cs_o == '0 && !re_o));
  assert_annul_no_err_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accepting && start_i && annul_i) |=> !err_o);
  assert_miss_no_cs_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accepting && start_i && hit == '0) |=> cs_o == '0);
  assert_accept_drives_cs_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accepting && start_i && !annul_i && hit != '0) |=> cs_o != '0);
endmodule

// File: tb/test_annul_xio_decoder.sv
module test_annul_xio_decoder;
  localparam int NWIN = 2, AW = 16, WAIT_W = 3, NS = 12;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic start = 1'b0, write = 1'b0, annul = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [NWIN-1:0][AW-1:0] base, mask;
  logic [NWIN-1:0][WAIT_W-1:0] wcnt;
  logic [NWIN-1:0] skip;
  logic [NWIN-1:0] cs;
  logic we, re, rdy, err;

  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  annul_xio_decoder #(.NWIN(NWIN), .AW(AW), .WAIT_W(WAIT_W)) i_annul_xio_decoder (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .write_i(write), .addr_i(addr),
    .annul_i(annul), .win_base_i(base), .win_mask_i(mask), .win_wait_i(wcnt),
    .win_rd_skip_i(skip), .cs_o(cs), .we_o(we), .re_o(re), .rdy_o(rdy), .err_o(err)
  );

  // {wr, addr, annul_first, annul_later, exp_cs, exp_we, exp_re, exp_rdy_sample, exp_err}
  localparam logic [27:0] VECS [9] = '{
    {1'b0, 16'h4010, 1'b0, 1'b0, 2'b01, 1'b0, 1'b1, 4'd4, 1'b0},
    {1'b1, 16'h4020, 1'b0, 1'b1, 2'b01, 1'b1, 1'b0, 4'd4, 1'b0},
    {1'b1, 16'h4030, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0, 4'd0, 1'b0},
    {1'b0, 16'h4040, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0, 4'd0, 1'b0},
    {1'b0, 16'h8010, 1'b1, 1'b0, 2'b10, 1'b0, 1'b1, 4'd2, 1'b0},
    {1'b1, 16'h8020, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0, 4'd0, 1'b0},
    {1'b0, 16'h1234, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 4'd0, 1'b1},
    {1'b1, 16'h1234, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0, 4'd0, 1'b0},
    {1'b1, 16'h8030, 1'b0, 1'b1, 2'b10, 1'b1, 1'b0, 4'd2, 1'b0}
  };
  string vec_tag [9] = '{"R2 R10", "R3 R7", "R4", "R5", "R6 R10", "R4", "R8", "R8", "R7"};

  logic [NWIN-1:0] o_cs;
  logic o_we, o_re, o_err;
  logic [3:0] o_rdy_first;
  int o_rdy_cnt;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic sample(input int k);
    o_cs |= cs;
    if (we) o_we = 1'b1;
    if (re) o_re = 1'b1;
    if (err) o_err = 1'b1;
    if (rdy) begin
      if (o_rdy_cnt == 0) o_rdy_first = 4'(k);
      o_rdy_cnt++;
    end
  endtask

  task automatic clear_obs();
    o_cs = '0; o_we = 1'b0; o_re = 1'b0; o_err = 1'b0; o_rdy_first = '0; o_rdy_cnt = 0;
  endtask

  task automatic xfer(input logic wr, input logic [AW-1:0] a, input logic an0, input logic an1);
    clear_obs();
    @(negedge clk);
    start = 1'b1; write = wr; addr = a; annul = an0;
    for (int k = 1; k <= NS; k++) begin
      @(negedge clk);
      if (k == 1) begin start = 1'b0; annul = an1; end
      sample(k);
    end
    annul = 1'b0;
  endtask

  initial begin
    base = {16'h8000, 16'h4000};
    mask = {16'hFF00, 16'hF000};
    wcnt = {3'd0, 3'd2};
    skip = 2'b10;
    repeat (3) @(negedge clk);
    check({cs, we, re, rdy, err} == '0, "R1 reset", 32'({cs, we, re, rdy, err}), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check({cs, we, re, rdy, err} == '0, "R1 idle", 32'({cs, we, re, rdy, err}), 0);

    for (int v = 0; v < 9; v++) begin
      xfer(VECS[v][27], VECS[v][26:11], VECS[v][10], VECS[v][9]);
      check({o_cs, o_we, o_re} == VECS[v][8:5], vec_tag[v], 32'({o_cs, o_we, o_re}), 32'(VECS[v][8:5]));
      check(o_rdy_first == VECS[v][4:1] && o_rdy_cnt == (VECS[v][4:1] != 0 ? 1 : 0),
            vec_tag[v], 32'(o_rdy_first), 32'(VECS[v][4:1]));
      check(o_err == VECS[v][0], vec_tag[v], 32'(o_err), 32'(VECS[v][0]));
    end

    // R9: both windows hit, window 0 (wait 2) wins
    base[1] = 16'h4000; mask[1] = 16'hF000;
    xfer(1'b0, 16'h4050, 1'b0, 1'b0);
    check(o_cs == 2'b01 && o_rdy_first == 4'd4, "R9 priority", 32'({o_cs, o_rdy_first}), 32'h14);
    base[1] = 16'h8000; mask[1] = 16'hFF00;

    // R10: longest wait
    wcnt[0] = 3'd7;
    xfer(1'b0, 16'h4060, 1'b0, 1'b0);
    check(o_rdy_first == 4'd9 && o_rdy_cnt == 1, "R10 wait7", 32'(o_rdy_first), 9);
    wcnt[0] = 3'd2;

    // R11: start during wait phase ignored
    clear_obs();
    @(negedge clk);
    start = 1'b1; write = 1'b0; addr = 16'h4010; annul = 1'b0;
    for (int k = 1; k <= NS; k++) begin
      @(negedge clk);
      start = (k == 2); write = (k == 2); addr = (k == 2) ? 16'h8010 : 16'h4010;
      sample(k);
    end
    check(o_cs == 2'b01 && !o_we, "R11 busy start cs/we", 32'({o_cs, o_we}), 32'h2);
    check(o_rdy_first == 4'd4 && o_rdy_cnt == 1, "R11 busy start rdy", 32'(o_rdy_cnt), 1);

    // R7: back-to-back, early annul through wait phase, then cancelled third start
    @(negedge clk);
    start = 1'b1; write = 1'b0; addr = 16'h4010; annul = 1'b0;
    for (int k = 1; k <= 11; k++) begin
      @(negedge clk);
      start = 1'b0; annul = 1'b1;
      if (k == 4) check(rdy == 1'b1, "R7 first rdy under early annul", 32'(rdy), 1);
      if (k == 5) check(we && cs == 2'b01, "R7 second write accepted", 32'({cs, we}), 32'h3);
      if (k == 8) check(rdy == 1'b1, "R7 second rdy", 32'(rdy), 1);
      if (k == 9 || k == 10)
        check({cs, we, re, rdy} == '0, "R7 R4 third cancelled", 32'({cs, we, re, rdy}), 0);
      if (k == 4) begin start = 1'b1; write = 1'b1; addr = 16'h4020; annul = 1'b0; end
      if (k == 8) begin start = 1'b1; write = 1'b1; addr = 16'h4030; annul = 1'b1; end
    end
    annul = 1'b0;

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule